// File: doc/BRIEF.md
# Bidirectional Parallel-to-Serial Converter

This block takes a parallel word and sends it out as a stream of single bits, one bit per clock while the shift enable is held. A direction input is sampled on every shifted cycle. A value of 1 sends from the low end, so the LSB goes first. A value of 0 sends from the high end, so the MSB goes first. The direction may change from one bit to the next.

An internal down-counter holds the number of bits still to be sent. Once every bit has gone out, the next shifted cycle raises a completion flag. A valid flag marks that at least one bit of the current word has appeared on the serial output.

The asynchronous active-low reset is released through a two-stage synchronizer before it reaches the core. Framing and any receiver handshake belong to the surrounding logic.

Top module: `pword_serializer`

## Requirements
- R1: While `rst_n` is low, `sdata_o`, `valid_o` and `done_o` are 0 without waiting for a clock, and the internal word and bit counter are cleared.
- R2: A clock edge with `load_i` high copies `pdata_i` into the shift register and sets the bit counter to 16. It drives `valid_o` and `done_o` to 0 and leaves `sdata_o` unchanged.
- R3: When `load_i` and `shift_i` are both high on the same edge, the load takes effect and no bit is sent.
- R4: On an edge with `shift_i` high, `load_i` low and a nonzero counter, the register shifts by one place and the vacated bit becomes 0. When `dir_i`=1 it shifts toward bit 0 and `sdata_o` takes the pre-shift bit 0. When `dir_i`=0 it shifts toward bit 15 and `sdata_o` takes the pre-shift bit 15.
- R5: Every such sent bit sets `valid_o` to 1, keeps `done_o` at 0 and lowers the counter by one, so exactly 16 bits go out per load.
- R6: On an edge with `shift_i` high, `load_i` low and the counter at 0, `done_o` becomes 1. This happens one clock after the last bit, and `valid_o` stays 1.
- R7: On an edge with `load_i` and `shift_i` both low, the register, counter and all three outputs keep their values.
- R8: A change of `dir_i` between bits acts on the current register contents, including zeros already shifted in.
- R9: After reset and before any load, the counter is 0, so a shifted cycle raises `done_o` at once and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load parallel word and preset counter |
| shift_i | input | 1 | Shift enable |
| dir_i | input | 1 | 1 = LSB first (shift toward bit 0), 0 = MSB first |
| pdata_i | input | 16 | Parallel word |
| sdata_o | output | 1 | Serial data bit |
| valid_o | output | 1 | Set by the first sent bit, cleared by load or reset |
| done_o | output | 1 | End of conversion |

## Verification
Asymmetric words such as 0xA5C3 are sent in each direction. A bit-order swap or a wrong end of the register would give a different stream. A word with only its two end bits set is loaded while shift is also high, which shows whether load wins and whether the first bit comes from the pre-shift register. Streams that change direction between bits, with pauses, expose wrong zero fill and wrong hold behaviour. A reload part way through a word, a reset part way through a word, and a shift with no load after reset check the counter bounds and the timing of the completion flag.

// File: rtl/ps_pkg.sv
package ps_pkg;
  // Operation chosen for the current cycle, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_SEND = 2'd2,
    OP_DONE = 2'd3
  } ps_op_e;

  localparam logic DIR_MSB_FIRST = 1'b0;
  localparam logic DIR_LSB_FIRST = 1'b1;
endpackage

// File: rtl/ps_rst_sync.sv
module ps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ps_ctrl.sv
module ps_ctrl
  import ps_pkg::*;
(
  input  logic   load,
  input  logic   shift,
  input  logic   cnt_zero,
  output ps_op_e op
);
  // Load has the highest priority, then shift.
  always_comb begin
    if (load) begin
      op = OP_LOAD;
    end else if (shift && !cnt_zero) begin
      op = OP_SEND;
    end else if (shift) begin
      op = OP_DONE;
    end else begin
      op = OP_HOLD;
    end
  end
endmodule

// File: rtl/ps_shreg.sv
module ps_shreg
  import ps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ps_op_e            op,
  input  logic              dir,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_q,
  output logic              tx_bit
);
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] shr;
  logic [WORD_W-1:0] shl;
  logic              word_en;

  // Zero-filled shifted views of the register, built bit by bit.
  genvar gi;
  generate
    for (gi = 0; gi < WORD_W; gi++) begin : g_shift
      if (gi == WORD_W - 1) begin : g_top
        assign shr[gi] = 1'b0;
      end else begin : g_mid_r
        assign shr[gi] = word_q[gi+1];
      end
      if (gi == 0) begin : g_bot
        assign shl[gi] = 1'b0;
      end else begin : g_mid_l
        assign shl[gi] = word_q[gi-1];
      end
    end
  endgenerate

  // Outgoing bit from the pre-shift register contents.
  assign tx_bit = (dir == DIR_LSB_FIRST) ? word_q[0] : word_q[WORD_W-1];

  always_comb begin
    word_en = 1'b0;
    word_d  = word_q;
    unique case (op)
      OP_LOAD: begin
        word_en = 1'b1;
        word_d  = din;
      end
      OP_SEND: begin
        word_en = 1'b1;
        word_d  = (dir == DIR_LSB_FIRST) ? shr : shl;
      end
      default: begin
        word_en = 1'b0;
        word_d  = word_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/ps_bitcnt.sv
module ps_bitcnt
  import ps_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ps_op_e           op,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    unique case (op)
      OP_LOAD: begin
        cnt_en = 1'b1;
        cnt_d  = CNT_FULL;
      end
      OP_SEND: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - CNT_ONE;
      end
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pword_serializer.sv
module pword_serializer
  import ps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              dir_i,
  input  logic [WORD_W-1:0] pdata_i,
  output logic              sdata_o,
  output logic              valid_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic             rst_core_n;
  ps_op_e           op;
  logic [WORD_W-1:0] word_q;
  logic             tx_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic             cnt_zero;

  logic sdo_q, sdo_d;
  logic vld_q, vld_d;
  logic eoc_q, eoc_d;
  logic out_en;

  ps_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  ps_ctrl u_ctrl (
    .load     (load_i),
    .shift    (shift_i),
    .cnt_zero (cnt_zero),
    .op       (op)
  );

  ps_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .op     (op),
    .dir    (dir_i),
    .din    (pdata_i),
    .word_q (word_q),
    .tx_bit (tx_bit)
  );

  ps_bitcnt #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_bitcnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .op       (op),
    .cnt_q    (bit_cnt),
    .cnt_zero (cnt_zero)
  );

  // Output flag next-state logic.
  always_comb begin
    out_en = 1'b1;
    sdo_d  = sdo_q;
    vld_d  = vld_q;
    eoc_d  = eoc_q;
    unique case (op)
      OP_LOAD: begin
        vld_d = 1'b0;
        eoc_d = 1'b0;
      end
      OP_SEND: begin
        sdo_d = tx_bit;
        vld_d = 1'b1;
        eoc_d = 1'b0;
      end
      OP_DONE: begin
        eoc_d = 1'b1;
      end
      default: begin
        out_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sdo_q <= 1'b0;
      vld_q <= 1'b0;
      eoc_q <= 1'b0;
    end else if (out_en) begin
      sdo_q <= sdo_d;
      vld_q <= vld_d;
      eoc_q <= eoc_d;
    end
  end

  assign sdata_o = sdo_q;
  assign valid_o = vld_q;
  assign done_o  = eoc_q;
endmodule

// File: rtl/pword_serializer_chk.sv
module pword_serializer_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              shift,
  input logic              dir,
  input logic              sdo,
  input logic              dv,
  input logic              eoc,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] word
);
  // R2: load presets the counter and clears both flags
  a_r2_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == CNT_W'(WORD_W)) && !dv && !eoc);

  // R3: load wins over shift, no bit goes out
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load && shift) |=> $stable(sdo) && (cnt == CNT_W'(WORD_W)));

  // R4: LSB-first bit comes from pre-shift bit 0
  a_r4_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift && cnt != '0 && dir) |=> (sdo == $past(word[0])));

  // R4: MSB-first bit comes from pre-shift top bit
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift && cnt != '0 && !dir) |=> (sdo == $past(word[WORD_W-1])));

  // R5: a sent bit raises valid, keeps done low, counts down
  a_r5_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift && cnt != '0) |=> dv && !eoc && (cnt == $past(cnt) - CNT_W'(1)));

  // R5: counter never exceeds the word width
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));

  // R6: shift with an empty counter raises done
  a_r6_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift && cnt == '0) |=> eoc && (cnt == '0) && $stable(dv));

  // R7: idle cycles change nothing
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sdo) && $stable(dv) && $stable(eoc)
                         && $stable(cnt) && $stable(word));
endmodule

bind pword_serializer pword_serializer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .load  (load_i),
  .shift (shift_i),
  .dir   (dir_i),
  .sdo   (sdata_o),
  .dv    (valid_o),
  .eoc   (done_o),
  .cnt   (bit_cnt),
  .word  (word_q)
);

// File: tb/test_pword_serializer.sv
module test_pword_serializer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i, shift_i, dir_i;
  logic [W-1:0] pdata_i;
  logic         sdata_o, valid_o, done_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit ended  = 0;

  typedef struct {
    int    due;
    logic  s;
    logic  v;
    logic  e;
    string tag;
  } exp_t;
  exp_t sb[$];

  // Bench reference state, written from the requirements.
  logic [W-1:0] m_word;
  int           m_cnt;
  logic         m_s, m_v, m_e;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pword_serializer #(.WORD_W(W)) i_pword_serializer (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .shift_i(shift_i),
    .dir_i(dir_i), .pdata_i(pdata_i),
    .sdata_o(sdata_o), .valid_o(valid_o), .done_o(done_o)
  );

  task automatic report(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {sdata,valid,done} actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops results that are due after this cycle's edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      report(it.tag, {sdata_o, valid_o, done_o}, {it.s, it.v, it.e});
    end
  end

  task automatic model_reset();
    m_word = '0; m_cnt = 0; m_s = 1'b0; m_v = 1'b0; m_e = 1'b0;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic ld, input logic sh, input logic dr,
                      input logic [W-1:0] d, input string tag);
    exp_t it;
    @(posedge clk); #1;
    load_i = ld; shift_i = sh; dir_i = dr; pdata_i = d;
    if (ld) begin
      m_word = d; m_cnt = W; m_v = 1'b0; m_e = 1'b0;
    end else if (sh && m_cnt != 0) begin
      m_s    = dr ? m_word[0] : m_word[W-1];
      m_word = dr ? (m_word >> 1) : (m_word << 1);
      m_cnt  = m_cnt - 1;
      m_v    = 1'b1;
      m_e    = 1'b0;
    end else if (sh) begin
      m_e = 1'b1;
    end
    it.due = cyc + 1; it.s = m_s; it.v = m_v; it.e = m_e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic drain();
    @(posedge clk); #1;
    load_i = 1'b0; shift_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; shift_i = 1'b0; dir_i = 1'b0; pdata_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    report("R1 reset state", {sdata_o, valid_o, done_o}, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9: shift before any load, counter starts empty
    step(1'b0, 1'b1, 1'b1, '0, "R9 shift without load");
    step(1'b0, 1'b1, 1'b0, '0, "R9 shift without load");
    // R2: a load clears done again
    step(1'b1, 1'b0, 1'b1, 16'hA5C3, "R2 load");
    idle(2, "R7 idle after load");

    // R4: LSB-first stream, then R6 completion
    for (int i = 0; i < W; i++) step(1'b0, 1'b1, 1'b1, '0, "R4 lsb-first bit");
    step(1'b0, 1'b1, 1'b1, '0, "R6 done after last bit");
    step(1'b0, 1'b1, 1'b0, '0, "R6 done held");
    idle(2, "R7 hold after done");

    // R4: MSB-first stream of the same word
    step(1'b1, 1'b0, 1'b0, 16'hA5C3, "R2 load");
    for (int i = 0; i < W; i++) step(1'b0, 1'b1, 1'b0, '0, "R4 msb-first bit");
    step(1'b0, 1'b1, 1'b0, '0, "R6 done after last bit");

    // R3: load with shift also high, first bit from pre-shift register
    step(1'b1, 1'b1, 1'b0, 16'h8001, "R3 load over shift");
    step(1'b0, 1'b1, 1'b0, '0, "R3 first msb bit");
    step(1'b0, 1'b1, 1'b1, '0, "R8 switch to lsb");
    step(1'b0, 1'b1, 1'b1, '0, "R8 lsb after switch");
    step(1'b0, 1'b1, 1'b0, '0, "R8 zero fill seen msb");

    // R8: mixed directions with pauses on a fresh word
    step(1'b1, 1'b0, 1'b1, 16'h1234, "R2 reload mid word");
    for (int i = 0; i < W; i++) begin
      step(1'b0, 1'b1, logic'(i % 3 == 0), '0, "R8 mixed direction bit");
      if (i % 5 == 2) step(1'b0, 1'b0, 1'b1, '0, "R7 pause mid word");
    end
    step(1'b0, 1'b1, 1'b1, '0, "R6 done after mixed word");

    // R5: count check, done must not rise after 15 bits
    step(1'b1, 1'b0, 1'b1, 16'hFFFF, "R2 load");
    for (int i = 0; i < W - 1; i++) step(1'b0, 1'b1, 1'b1, '0, "R5 bit count");
    step(1'b0, 1'b0, 1'b0, '0, "R7 pause before last bit");
    step(1'b0, 1'b1, 1'b1, '0, "R5 sixteenth bit");
    step(1'b0, 1'b1, 1'b1, '0, "R6 done after sixteenth");

    // R1: reset part way through a word
    step(1'b1, 1'b0, 1'b1, 16'h7FFF, "R2 load");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, '0, "R4 lsb-first bit");
    drain();
    rst_n = 1'b0;
    #1;
    report("R1 asynchronous clear", {sdata_o, valid_o, done_o}, 3'b000);
    model_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(1'b0, 1'b1, 1'b1, '0, "R1 counter cleared by reset");
    step(1'b1, 1'b0, 1'b0, 16'h0F0F, "R2 load after reset");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, '0, "R4 msb-first bit");
    drain();
    finish_run();
  end
endmodule